// File: doc/BRIEF.md
# Two-of-Four Structured Sparse Dot-Product Unit

This unit computes a signed dot product between a weight row that has been pruned to a fixed two-of-four pattern and a dense activation vector. In every group of four weight positions only two values survive. The unit receives just those two values per group, together with a small position tag, and so it never spends a multiply cycle on a pruned position. The tag for a tile is loaded in a one-cycle prologue. The compressed weights then stream in, one per accepted beat. For each stored weight the tag picks the activation lane that weight pairs with, and the product is added into a wide accumulator.

A tile of `GROUPS` groups covers `4*GROUPS` activation lanes. It needs `2*GROUPS` multiply beats plus the single tag cycle, where a dense unit with one multiplier would need `4*GROUPS` beats. Three per-tile control flags, sampled with the tag, drive the accumulator. The start flag clears it before the tile. The accumulate flag lets the tile's products in. The stop flag marks the tile's end value as final. The pattern is fixed when the model is built and nothing is discovered at run time. A tag that names the same position twice within a group is reported, and that group contributes nothing.

Top module: `s24_dot_unit`

## Requirements
- R1: A tile opens when `tag_load` is high while `busy` is low. For group g, tag bits [4g+1:4g] give the position of the group's first stored weight and bits [4g+3:4g+2] give the position of its second. Position p (0 to 3) selects activation lane 4g+p, which is read from `act_in[(4g+p)*AW +: AW]`.
- R2: Weights arrive in slot order: group 0 first weight, group 0 second weight, group 1 first weight, and so on, one per cycle with `w_valid` high. Weights and activations are two's complement. The sum a tile adds equals the dense dot product of the activations with the weight row rebuilt by putting zeros back at the pruned positions.
- R3: A tile ends on the edge that accepts its `2*GROUPS`-th weight beat. `busy` is high from the edge after the tag load up to that edge. Cycles with `w_valid` low inside a tile stall the sequence and do not advance it.
- R4: With `cf_start` high at the tag load, `acc_out` is zero on the edge that accepts the tag.
- R5: With `cf_accum` low at the tag load, the tile's products are discarded and `acc_out` holds its value through the tile.
- R6: With `cf_stop` high at the tag load, `res_valid` pulses high for exactly one cycle, starting at the edge of the tile's last beat. With `cf_stop` low, `res_valid` stays low.
- R7: If any group's two position fields are equal, `tag_fault` goes high on the edge after the tag load and stays high until the next accepted tag load. Both weights of such a group contribute zero, and the other groups are unaffected.
- R8: `tag_load` while `busy` is high is ignored. The tag, the flags and the accumulator are not changed by it.
- R9: `w_valid` while `busy` is low is ignored, and `acc_out` does not change.
- R10: In the default configuration the accumulator is `ACCW` bits wide and wraps in two's complement on overflow.
- R11: After reset, `acc_out` is 0 and `busy`, `res_valid` and `tag_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tag_load | input | 1 | Prologue strobe that opens a tile |
| tag_in | input | 4*GROUPS | Position tag, two 2-bit fields per group |
| cf_start | input | 1 | Clear the accumulator before this tile |
| cf_accum | input | 1 | Add this tile's products into the accumulator |
| cf_stop | input | 1 | Mark the result final at the end of this tile |
| w_valid | input | 1 | Compressed weight beat present |
| w_data | input | WW | Compressed weight, signed |
| act_in | input | 4*GROUPS*AW | Dense activation lanes, signed, held for the tile |
| acc_out | output | ACCW | Accumulator value |
| res_valid | output | 1 | One-cycle pulse when a stop tile completes |
| busy | output | 1 | A tile is in progress |
| tag_fault | output | 1 | The loaded tag has a group with duplicate positions |

## Verification
The embedded properties check the cycle-level rules on every cycle. They cover the clearing of the accumulator at a start tag, the holding of the accumulator on idle beats, on tiles with accumulation off and on faulty groups, the single-cycle shape of the result pulse, the immunity of the loaded tag to loads during a tile, and the bound on the slot counter. The numeric results can only be shown by the bench scenarios. Those are the signed sums matched against a dense reference with the zeros put back, the carrying of a partial sum across tiles, the wrap after many large tiles, and correct sequencing when the weight stream has gaps.

// File: rtl/s24_pkg.sv
package s24_pkg;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_e;

   // A group tag nibble is {second_pos, first_pos}; equal fields are illegal.
   function automatic logic nib_clash(input logic [3:0] nib);
      return nib[1:0] == nib[3:2];
   endfunction

endpackage

// File: rtl/s24_tag_store.sv
module s24_tag_store #(
   parameter int GROUPS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [4*GROUPS-1:0]   tag_i,
   output logic [4*GROUPS-1:0]   tag_o,
   output logic [GROUPS-1:0]     bad_grp_o,
   output logic                  fault_o
);
   localparam int TW = 4 * GROUPS;
   localparam logic [TW-1:0] TAG_RST = {GROUPS{4'b0100}};

   logic [TW-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      tag_q <= TAG_RST;
      else if (load_i) tag_q <= tag_i;
   end

   genvar g;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         assign bad_grp_o[g] = s24_pkg::nib_clash(tag_q[4*g +: 4]);
      end
   endgenerate

   assign tag_o   = tag_q;
   assign fault_o = |bad_grp_o;

   // R7: the fault indication only moves when a new tag is taken
   assert_fault_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(fault_o));

endmodule

// File: rtl/s24_lane_pick.sv
module s24_lane_pick #(
   parameter int GROUPS = 4,
   parameter int AW     = 8
) (
   input  logic [$clog2(2*GROUPS)-1:0] slot_i,
   input  logic [4*GROUPS-1:0]         tag_i,
   input  logic [GROUPS-1:0]           bad_grp_i,
   input  logic [4*GROUPS*AW-1:0]      act_i,
   output logic [AW-1:0]               act_o,
   output logic                        keep_o
);
   localparam int NSLOT = 2 * GROUPS;

   logic [NSLOT*AW-1:0] cand;
   logic [NSLOT-1:0]    drop;

   genvar g, h;
   generate
      for (g = 0; g < GROUPS; g++) begin : g_grp
         for (h = 0; h < 2; h++) begin : g_half
            logic [1:0] pos;
            assign pos = tag_i[4*g + 2*h +: 2];
            assign cand[(2*g+h)*AW +: AW] =
               (pos == 2'd0) ? act_i[(4*g+0)*AW +: AW] :
               (pos == 2'd1) ? act_i[(4*g+1)*AW +: AW] :
               (pos == 2'd2) ? act_i[(4*g+2)*AW +: AW] :
                               act_i[(4*g+3)*AW +: AW];
            assign drop[2*g+h] = bad_grp_i[g];
         end
      end
   endgenerate

   assign act_o  = cand[slot_i*AW +: AW];
   assign keep_o = !drop[slot_i];

endmodule

// File: rtl/s24_mac.sv
module s24_mac #(
   parameter int WW     = 8,
   parameter int AW     = 8,
   parameter int ACCW   = 24,
   parameter bit SAT_EN = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            add_i,
   input  logic [WW-1:0]   w_i,
   input  logic [AW-1:0]   a_i,
   output logic [ACCW-1:0] acc_o
);
   localparam int PW = WW + AW;

   logic signed [PW-1:0] prod;
   logic [ACCW-1:0]      prod_x;
   logic [ACCW-1:0]      acc_q;
   logic [ACCW-1:0]      acc_nx;

   assign prod   = $signed(w_i) * $signed(a_i);
   assign prod_x = {{(ACCW-PW){prod[PW-1]}}, prod};

   generate
      if (SAT_EN) begin : g_sat
         logic [ACCW:0] sum;
         assign sum = {acc_q[ACCW-1], acc_q} + {prod_x[ACCW-1], prod_x};
         always_comb begin
            if (sum[ACCW] != sum[ACCW-1])
               acc_nx = sum[ACCW] ? {1'b1, {(ACCW-1){1'b0}}}
                                  : {1'b0, {(ACCW-1){1'b1}}};
            else
               acc_nx = sum[ACCW-1:0];
         end
      end else begin : g_wrap
         assign acc_nx = acc_q + prod_x;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     acc_q <= '0;
      else if (clr_i) acc_q <= '0;
      else if (add_i) acc_q <= acc_nx;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/s24_dot_unit.sv
module s24_dot_unit #(
   parameter int GROUPS = 4,
   parameter int WW     = 8,
   parameter int AW     = 8,
   parameter int ACCW   = 24,
   parameter bit SAT_EN = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tag_load,
   input  logic [4*GROUPS-1:0]      tag_in,
   input  logic                     cf_start,
   input  logic                     cf_accum,
   input  logic                     cf_stop,
   input  logic                     w_valid,
   input  logic [WW-1:0]            w_data,
   input  logic [4*GROUPS*AW-1:0]   act_in,
   output logic [ACCW-1:0]          acc_out,
   output logic                     res_valid,
   output logic                     busy,
   output logic                     tag_fault
);
   import s24_pkg::*;

   localparam int NSLOT = 2 * GROUPS;
   localparam int SLW   = $clog2(NSLOT);
   localparam int TW    = 4 * GROUPS;
   localparam logic [SLW-1:0] LAST_SLOT = SLW'(NSLOT - 1);

   generate
      if (GROUPS < 1)       begin : g_bad_groups $error("GROUPS must be at least 1"); end
      if (WW < 2 || AW < 2) begin : g_bad_width  $error("operand widths must be at least 2"); end
      if (ACCW <= WW + AW)  begin : g_bad_acc    $error("ACCW must exceed WW+AW"); end
   endgenerate

   phase_e          phase_q;
   logic [SLW-1:0]  slot_q;
   logic            f_accum_q;
   logic            f_stop_q;
   logic            res_q;

   logic            take;
   logic            beat;
   logic            last_beat;
   logic [TW-1:0]   tag_cur;
   logic [GROUPS-1:0] bad_grp;
   logic [AW-1:0]   act_sel;
   logic            keep;

   assign busy      = (phase_q == PH_RUN);
   assign take      = tag_load && !busy;
   assign beat      = w_valid && busy;
   assign last_beat = beat && (slot_q == LAST_SLOT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         slot_q    <= '0;
         f_accum_q <= 1'b0;
         f_stop_q  <= 1'b0;
         res_q     <= 1'b0;
      end else begin
         res_q <= last_beat && f_stop_q;
         if (take) begin
            phase_q   <= PH_RUN;
            slot_q    <= '0;
            f_accum_q <= cf_accum;
            f_stop_q  <= cf_stop;
         end else if (beat) begin
            slot_q <= slot_q + 1'b1;
            if (last_beat) phase_q <= PH_IDLE;
         end
      end
   end

   s24_tag_store #(.GROUPS(GROUPS)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (take),
      .tag_i     (tag_in),
      .tag_o     (tag_cur),
      .bad_grp_o (bad_grp),
      .fault_o   (tag_fault)
   );

   s24_lane_pick #(.GROUPS(GROUPS), .AW(AW)) u_pick (
      .slot_i    (slot_q),
      .tag_i     (tag_cur),
      .bad_grp_i (bad_grp),
      .act_i     (act_in),
      .act_o     (act_sel),
      .keep_o    (keep)
   );

   s24_mac #(.WW(WW), .AW(AW), .ACCW(ACCW), .SAT_EN(SAT_EN)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (take && cf_start),
      .add_i (beat && f_accum_q && keep),
      .w_i   (w_data),
      .a_i   (act_sel),
      .acc_o (acc_out)
   );

   assign res_valid = res_q;

   // R4: a start tag leaves the accumulator at zero on the next edge
   assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_load && !busy && cf_start) |=> (acc_out == '0));

   // R5: a tile loaded with accumulation off never moves the accumulator
   assert_noaccum_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && busy && !f_accum_q) |=> $stable(acc_out));

   // R7: a beat of a faulty group adds nothing
   assert_fault_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && busy && !keep) |=> $stable(acc_out));

   // R9: a weight beat outside a tile is dropped
   assert_idle_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (w_valid && !busy && !tag_load) |=> $stable(acc_out));

   // R8: a tag offered mid-tile leaves the held tag alone
   assert_busy_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_load && busy) |=> $stable(tag_fault));

   // R6: the result strobe is a single cycle closing a tile
   assert_res_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   assert_res_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (!busy && $past(busy)));

   // R3: the slot counter stays inside the tile
   assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(slot_q) < NSLOT));

endmodule

// File: tb/s24_dot_unit_bench.sv
module s24_dot_unit_bench;

   localparam int CLK_PERIOD = 10;
   localparam int G     = 4;
   localparam int WW    = 8;
   localparam int AW    = 8;
   localparam int ACCW  = 24;
   localparam int NSLOT = 2 * G;
   localparam int TW    = 4 * G;
   localparam int WV    = NSLOT * WW;
   localparam int LANES = 4 * G;

   typedef struct packed {
      logic [TW-1:0] tag;
      logic [WV-1:0] w;
      logic [7:0]    seed;
      logic          st;
      logic          ac;
      logic          sp;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VTAB [NVEC] = '{
      '{16'h9CE4, 64'h7F80_0102_FE03_1122, 8'h11, 1'b1, 1'b1, 1'b1},
      '{16'h3B6D, 64'h0A0B_F0F1_7E81_3355, 8'h29, 1'b1, 1'b1, 1'b0},
      '{16'h4E4E, 64'h8080_8080_8080_8080, 8'h80, 1'b0, 1'b1, 1'b1},
      '{16'h9CE4, 64'h1234_5678_9ABC_DEF0, 8'h42, 1'b1, 1'b0, 1'b1},
      '{16'h9C54, 64'h0506_0708_090A_0B0C, 8'h33, 1'b0, 1'b1, 1'b1},
      '{16'h3B6D, 64'h7F7F_7F7F_7F7F_7F7F, 8'h7F, 1'b1, 1'b1, 1'b1},
      '{16'hE4E4, 64'h0101_0101_0101_0101, 8'h05, 1'b0, 1'b0, 1'b1}
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                tag_load = 1'b0;
   logic [TW-1:0]       tag_in = '0;
   logic                cf_start = 1'b0;
   logic                cf_accum = 1'b0;
   logic                cf_stop = 1'b0;
   logic                w_valid = 1'b0;
   logic [WW-1:0]       w_data = '0;
   logic [LANES*AW-1:0] act_in = '0;
   logic [ACCW-1:0]     acc_out;
   logic                res_valid;
   logic                busy;
   logic                tag_fault;

   int n_checks = 0;
   int n_fails  = 0;
   logic [ACCW-1:0] model_acc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   s24_dot_unit #(.GROUPS(G), .WW(WW), .AW(AW), .ACCW(ACCW)) u_s24_dot_unit (
      .clk(clk), .rst_n(rst_n), .tag_load(tag_load), .tag_in(tag_in),
      .cf_start(cf_start), .cf_accum(cf_accum), .cf_stop(cf_stop),
      .w_valid(w_valid), .w_data(w_data), .act_in(act_in),
      .acc_out(acc_out), .res_valid(res_valid), .busy(busy), .tag_fault(tag_fault)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [LANES*AW-1:0] make_act(input logic [7:0] sd, input logic flat);
      logic [LANES*AW-1:0] v;
      for (int j = 0; j < LANES; j++)
         v[j*AW +: AW] = flat ? sd : AW'(int'(sd) + 37 * j);
      return v;
   endfunction

   function automatic logic tag_bad(input logic [TW-1:0] tg);
      logic b = 1'b0;
      for (int g = 0; g < G; g++)
         if (tg[4*g +: 2] == tg[4*g+2 +: 2]) b = 1'b1;
      return b;
   endfunction

   // Dense reference: rebuild the full weight row with zeros, then a plain dot product.
   function automatic longint dense_dot(input logic [TW-1:0] tg, input logic [WV-1:0] wv,
                                        input logic [LANES*AW-1:0] av);
      longint dense [LANES];
      longint s = 0;
      for (int j = 0; j < LANES; j++) dense[j] = 0;
      for (int g = 0; g < G; g++) begin
         int p0 = int'(tg[4*g +: 2]);
         int p1 = int'(tg[4*g+2 +: 2]);
         if (p0 != p1) begin
            dense[4*g+p0] = longint'($signed(wv[(2*g)*WW +: WW]));
            dense[4*g+p1] = longint'($signed(wv[(2*g+1)*WW +: WW]));
         end
      end
      for (int j = 0; j < LANES; j++)
         s += dense[j] * longint'($signed(av[j*AW +: AW]));
      return s;
   endfunction

   task automatic run_tile(input logic [TW-1:0] tg, input logic [WV-1:0] wv,
                           input logic [7:0] sd, input logic flat,
                           input logic st, input logic ac, input logic sp,
                           input logic gaps, input logic poke, input bit quiet);
      logic [LANES*AW-1:0] av = make_act(sd, flat);
      @(negedge clk);
      tag_load = 1'b1; tag_in = tg; cf_start = st; cf_accum = ac; cf_stop = sp;
      act_in = av;
      @(negedge clk);
      tag_load = 1'b0; cf_start = 1'b0; cf_accum = 1'b0; cf_stop = 1'b0;
      for (int s = 0; s < NSLOT; s++) begin
         if (gaps && s[0]) begin
            w_valid = 1'b0;
            @(negedge clk);
         end
         w_valid = 1'b1;
         w_data  = wv[s*WW +: WW];
         if (poke && s == 3) begin
            tag_load = 1'b1; tag_in = {G{4'b0101}}; cf_start = 1'b1;
         end
         @(negedge clk);
         tag_load = 1'b0; cf_start = 1'b0;
         if (!quiet && s == NSLOT - 2) begin
            w_valid = 1'b0;
            check("R3 busy before last beat", busy, 1);
            check("R6 no strobe before last beat", res_valid, 0);
         end
      end
      w_valid = 1'b0;
      if (st) model_acc = '0;
      if (ac) model_acc = ACCW'(longint'(model_acc) + dense_dot(tg, wv, av));
      if (!quiet || sp) check("R2 R5 R7 R10 accumulator", acc_out, model_acc);
      if (!quiet) begin
         check("R6 result strobe", res_valid, sp);
         check("R7 tag fault", tag_fault, tag_bad(tg));
         check("R3 idle after last beat", busy, 0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      logic [ACCW-1:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 acc after reset", acc_out, 0);
      check("R11 busy after reset", busy, 0);
      check("R11 strobe after reset", res_valid, 0);
      check("R11 fault after reset", tag_fault, 0);

      // R1 R2 R4 R5 R6 R7 table of tiles
      for (int i = 0; i < NVEC; i++)
         run_tile(VTAB[i].tag, VTAB[i].w, VTAB[i].seed, 1'b0,
                  VTAB[i].st, VTAB[i].ac, VTAB[i].sp, 1'b0, 1'b0, 1'b0);

      // R4: start clears on the tag edge
      @(negedge clk);
      tag_load = 1'b1; tag_in = 16'h9CE4; cf_start = 1'b1; cf_accum = 1'b1; cf_stop = 1'b1;
      @(negedge clk);
      tag_load = 1'b0;
      check("R4 cleared at tag edge", acc_out, 0);
      for (int s = 0; s < NSLOT; s++) begin
         w_valid = 1'b1; w_data = 8'h00;
         @(negedge clk);
      end
      w_valid = 1'b0;
      model_acc = '0;

      // R9: weight beats while idle are dropped
      run_tile(16'h9CE4, 64'h0102_0304_0506_0708, 8'h21, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      held = acc_out;
      w_valid = 1'b1; w_data = 8'h7F;
      repeat (3) @(negedge clk);
      w_valid = 1'b0;
      check("R9 idle beats ignored", acc_out, held);
      check("R9 still idle", busy, 0);

      // R3: gaps in the weight stream stall the sequence
      run_tile(16'h3B6D, 64'hF1E2_D3C4_B5A6_9788, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);

      // R8: a faulty start tag offered mid-tile is ignored
      run_tile(16'h4E4E, 64'h1122_3344_5566_7788, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);

      // R10: many large tiles wrap the accumulator
      run_tile(16'h9CE4, 64'h8080_8080_8080_8080, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      for (int k = 0; k < 68; k++)
         run_tile(16'h9CE4, 64'h8080_8080_8080_8080, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
      run_tile(16'h9CE4, 64'h8080_8080_8080_8080, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      check("R10 wrapped negative", acc_out[ACCW-1], 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule